// File: doc/BRIEF.md
# Byte-Wide Static Memory Model with Strobe Decoding

This block is a clock-sampled, synthesizable stand-in for a byte-wide asynchronous static memory. The memory has active-low chip-select, write-strobe and read-enable pins. Every edge of `clk` samples the pins. The block works out read and write cycles from the levels and edges of the strobes. It stores a byte when a write window closes and drives its data outputs only when a plain read is in progress. The bidirectional data bus is split into `din`, `dout` and `dout_en`. A board-level wrapper can join them into a tri-state pad.

The port-level address is 19 bits wide at full size. The storage array is a separate parameter, so that simulation can use a small array. Only the low `MEM_AW` address bits select a byte. The upper bits are accepted but ignored. A write-protect input, driven by a supply supervisor, blocks every access while it is high.

All timing is counted in clock cycles. A write window is open in every sampled cycle in which both chip-select and write-strobe are low. It opens on whichever of the two falls later and closes on whichever rises first. The byte stored is the `din` and `addr` sampled in the last cycle in which the window was open.

Top module: `bytewide_sram`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with the strobes idle, `dout_en` is 0, `dout` is 0 and `addr_err` is 0.
- R2: If a clock edge samples `ce_n`=0, `oe_n`=0, `we_n`=1 and `wr_prot`=0, then after that edge `dout_en` is 1 and `dout` holds the stored byte at the sampled address.
- R3: The window is open in each sampled cycle with `ce_n`=0 and `we_n`=0 (and `wr_prot`=0). It closes at the first edge that samples either of them high. The array is written only at that closing edge, with the `din` and `addr` of the last open cycle. This holds whether `we_n` or `ce_n` rises first.
- R4: An edge that samples `we_n`=0 leaves `dout_en` at 0 after it, whatever `ce_n` and `oe_n` are. This includes `we_n` falling before, with, or after `ce_n`.
- R5: An edge that samples `oe_n`=1 leaves `dout_en` at 0 after it, including during a write.
- R6: While `wr_prot` is 1, `dout_en` is 0 after every edge and no byte is written. A window that is open when `wr_prot` rises is abandoned without a write.
- R7: If the address changes between two consecutive edges at which the window stays open, `addr_err` is 1 for the one cycle after the second edge. Otherwise it is 0.
- R8: Only address bits `[MEM_AW-1:0]` select the byte. Two addresses that differ only above that bit reach the same byte.
- R9: `dout` is 0 whenever `dout_en` is 0.
- R10: With `ce_n`=1, toggling `we_n` and `din` writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_prot | input | 1 | Supervisor write protect, blocks all access |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data toward the bus, 0 when not driven |
| dout_en | output | 1 | High when the data pad should be driven |
| addr_err | output | 1 | One-cycle pulse: address moved inside an open window |

## Verification
The assertions assume that the strobes, address and data only change between clock edges. They also assume that the strobes are idle, with all three high, while reset is held, because the checks look one sample into the past. The bench drives every input on the falling clock edge and idles the strobes throughout reset. A small configuration is used, with a 6-bit array behind an 8-bit address. The bench writes every byte, using both strobe orders and aliased upper address bits. It then reads every byte back through a different alias, comparing against a value computed from the address. This is followed by targeted cycles for protect, strobe overlap and address movement inside a window.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
package bsram_pkg;
   // Per-cycle decisions handed from the strobe decoder to array and outputs
   typedef struct packed {
      logic wr_fire;  // window closed at this edge: commit the latched byte
      logic rd_on;    // plain read sampled at this edge
   } bsram_ctl_t;
endpackage

// File: rtl/bsram_strobe_dec.sv
`timescale 1ns/1ps
module bsram_strobe_dec
   import bsram_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_prot,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output bsram_ctl_t        ctl,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              addr_err
);
   logic              win_raw;
   logic              win_live;
   logic              win_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] din_q;
   logic              err_q;

   // Window is the AND of the two low strobes; protect forces it shut
   assign win_raw  = ~ce_n & ~we_n;
   assign win_live = win_raw & ~wr_prot;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q  <= 1'b0;
         addr_q <= '0;
         din_q  <= '0;
         err_q  <= 1'b0;
      end else begin
         win_q <= win_live;
         if (win_live) begin
            addr_q <= addr;
            din_q  <= din;
         end
         err_q <= win_q & win_live & (addr != addr_q);
      end
   end

   // Commit at the first edge that sees the window shut, unless protected
   assign ctl.wr_fire = win_q & ~win_raw & ~wr_prot;
   assign ctl.rd_on   = ~ce_n & ~oe_n & we_n & ~wr_prot;
   assign wr_addr     = addr_q;
   assign wr_data     = din_q;
   assign addr_err    = err_q;

   // R3: a commit only follows a cycle in which both strobes were low
   p_commit_after_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.wr_fire |-> $past(!ce_n && !we_n && !wr_prot));

   // R6: nothing is committed while protect is high
   p_no_commit_protected_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_prot |-> !ctl.wr_fire);
endmodule

// File: rtl/bsram_array.sv
`timescale 1ns/1ps
module bsram_array #(
   parameter int ADDR_W = 19,
   parameter int MEM_AW = 10,
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << MEM_AW;

   logic [MEM_AW-1:0] wr_idx;
   logic [MEM_AW-1:0] rd_idx;
   logic [DATA_W-1:0] mem [DEPTH];

   // Full-size array uses every address bit; a reduced one aliases on the low bits
   generate
      if (MEM_AW == ADDR_W) begin : g_full
         assign wr_idx = wr_addr;
         assign rd_idx = rd_addr;
      end else begin : g_alias
         assign wr_idx = wr_addr[MEM_AW-1:0];
         assign rd_idx = rd_addr[MEM_AW-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
   end

   assign rd_data = mem[rd_idx];
endmodule

// File: rtl/bsram_out_stage.sv
`timescale 1ns/1ps
module bsram_out_stage #(
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_on,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);
   logic [DATA_W-1:0] dout_q;
   logic              en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout_q <= '0;
         en_q   <= 1'b0;
      end else if (rd_on) begin
         dout_q <= rd_data;
         en_q   <= 1'b1;
      end else begin
         dout_q <= '0;
         en_q   <= 1'b0;
      end
   end

   assign dout    = dout_q;
   assign dout_en = en_q;

   // R9: an undriven pad carries zero
   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (dout_q == '0));
endmodule

// File: rtl/bytewide_sram.sv
`timescale 1ns/1ps
module bytewide_sram
   import bsram_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int MEM_AW = 10,
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_prot,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              addr_err
);
   // Elaboration checks on the configuration
   generate
      if (MEM_AW < 1 || MEM_AW > ADDR_W) begin : g_bad_aw
         $error("MEM_AW must lie in 1..ADDR_W");
      end
      if (ADDR_W > 24) begin : g_bad_addr
         $error("ADDR_W above 24 is not supported");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("DATA_W must be positive");
      end
   endgenerate

   bsram_ctl_t        ctl;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rd_data;

   bsram_strobe_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dec_i (
      .clk(clk), .rst_n(rst_n), .wr_prot(wr_prot),
      .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .din(din),
      .ctl(ctl), .wr_addr(wr_addr), .wr_data(wr_data), .addr_err(addr_err)
   );

   bsram_array #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .DATA_W(DATA_W)) mem_i (
      .clk(clk), .wr_en(ctl.wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(addr), .rd_data(rd_data)
   );

   bsram_out_stage #(.DATA_W(DATA_W)) out_i (
      .clk(clk), .rst_n(rst_n), .rd_on(ctl.rd_on), .rd_data(rd_data),
      .dout(dout), .dout_en(dout_en)
   );

   // R2: a sampled plain read drives the pad on the next cycle
   p_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && we_n && !wr_prot) |=> dout_en);

   // R4: a low write strobe keeps the pad off
   p_we_blocks_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |=> !dout_en);

   // R5: read enable high keeps the pad off
   p_oe_blocks_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |=> !dout_en);

   // R6: protect keeps the pad off
   p_prot_blocks_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_prot |=> !dout_en);

   // R7: the error pulse only follows an open window
   p_err_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |-> $past(!ce_n && !we_n && !wr_prot));
endmodule

// File: tb/bytewide_sram_tb_top.sv
`timescale 1ns/1ps
module bytewide_sram_tb_top;
   localparam int AW  = 8;
   localparam int MAW = 6;
   localparam int DW  = 8;
   localparam int NB  = 1 << MAW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_prot = 1'b0;
   logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en, addr_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [DW-1:0] model [NB];

   always #2.5 clk = ~clk;

   bytewide_sram #(.ADDR_W(AW), .MEM_AW(MAW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_prot(wr_prot),
      .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .din(din),
      .dout(dout), .dout_en(dout_en), .addr_err(addr_err)
   );

   function automatic logic [DW-1:0] pat(int a, int salt);
      return DW'((a * 37 + 11 + salt * 101) ^ 8'h5A);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
   endtask

   // style 0: write strobe inside chip select; style 1: chip select inside write strobe
   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, bit style);
      @(negedge clk); addr = a; din = d; oe_n = 1'b1;
      if (!style) begin ce_n = 1'b0; we_n = 1'b1; end
      else        begin we_n = 1'b0; ce_n = 1'b1; end
      @(negedge clk); if (!style) we_n = 1'b0; else ce_n = 1'b0;
      @(negedge clk);
      @(negedge clk); din = ~d; if (!style) we_n = 1'b1; else ce_n = 1'b1;
      @(negedge clk); idle();
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d, output logic en);
      @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      @(negedge clk); d = dout; en = dout_en; idle();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d;
      logic en;
      repeat (4) @(negedge clk);
      chk("R1 dout_en in reset", 32'(dout_en), 0);
      chk("R1 dout in reset", 32'(dout), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R1 dout_en after reset", 32'(dout_en), 0);
      chk("R1 addr_err after reset", 32'(addr_err), 0);

      // R3/R8: fill every byte through an alias, alternating strobe order
      for (int a = 0; a < NB; a++) begin
         model[a] = pat(a, 0);
         wr(AW'({2'(a % 4), 6'(a)}), model[a], a[0]);
      end
      for (int a = 0; a < NB; a++) begin
         rd(AW'({2'((a + 1) % 4), 6'(a)}), d, en);
         chk("R2 read enable", 32'(en), 1);
         chk("R3 R8 readback", 32'(d), 32'(model[a]));
      end

      // R4: write strobe low with chip select and read enable low -> pad off, byte written
      @(negedge clk); addr = 8'd5; din = pat(5, 1); oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      chk("R4 dout_en with we low", 32'(dout_en), 0);
      chk("R9 dout zero when off", 32'(dout), 0);
      we_n = 1'b1; din = 8'h00;
      @(negedge clk); idle(); model[5] = pat(5, 1);
      rd(8'd5, d, en);
      chk("R3 overlap write", 32'(d), 32'(model[5]));

      // R5: read enable high
      @(negedge clk); addr = 8'd7; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);
      chk("R5 dout_en with oe high", 32'(dout_en), 0);
      idle();

      // R10: chip select high, strobe toggles -> nothing written
      @(negedge clk); addr = 8'd9; din = 8'hC3; ce_n = 1'b1; we_n = 1'b0;
      @(negedge clk); we_n = 1'b1; din = 8'h3C;
      @(negedge clk); we_n = 1'b0;
      @(negedge clk); idle();
      rd(8'd9, d, en);
      chk("R10 deselected write ignored", 32'(d), 32'(model[9]));

      // R6: protected full write, protected read, window abandoned on protect
      wr_prot = 1'b1;
      wr(8'd11, 8'hEE, 1'b0);
      rd(8'd11, d, en);
      chk("R6 no output when protected", 32'(en), 0);
      wr_prot = 1'b0;
      rd(8'd11, d, en);
      chk("R6 protected write discarded", 32'(d), 32'(model[11]));
      @(negedge clk); addr = 8'd12; din = 8'h77; ce_n = 1'b0;
      @(negedge clk); we_n = 1'b0;
      @(negedge clk); wr_prot = 1'b1;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk); wr_prot = 1'b0; idle();
      rd(8'd12, d, en);
      chk("R6 window abandoned", 32'(d), 32'(model[12]));

      // R7: address moves inside an open window
      @(negedge clk); addr = 8'd20; din = pat(21, 2); ce_n = 1'b0;
      @(negedge clk); we_n = 1'b0;
      @(negedge clk);
      chk("R7 no error on stable address", 32'(addr_err), 0);
      addr = 8'd21;
      @(negedge clk);
      chk("R7 error pulse", 32'(addr_err), 1);
      @(negedge clk);
      chk("R7 error clears", 32'(addr_err), 0);
      we_n = 1'b1;
      @(negedge clk); idle(); model[21] = pat(21, 2);
      rd(8'd21, d, en);
      chk("R3 R7 byte at last address", 32'(d), 32'(model[21]));
      rd(8'd20, d, en);
      chk("R7 first address untouched", 32'(d), 32'(model[20]));

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule